// File: doc/BRIEF.md
# Interleaved Block Memory Responder

This block is the main-memory side of a cache refill path. A requester asks for a block of four words by giving a block address. The memory returns the words over a data bus that is one word wide. Each word of a block is held in its own bank, so word k of every block is stored in bank k. When a request arrives, all four banks start their access together. Once the shared access latency has passed, the four words leave on four back-to-back cycles. The cost of a block read is therefore one address cycle, one access latency and four transfer cycles.

The block also accepts block writes. The address cycle is followed by four data cycles, and the responder then stays busy for the bank write time. A parameter can switch the same datapath to non-interleaved timing. In that mode each word waits for its own full access before it transfers, which gives the longer baseline for comparison. Only one request is in flight at a time, and busy covers the whole transaction.

Top module: `iv_mem_responder`

## Requirements
- R1: After a synchronous active-low reset, busy and rd_valid are low, rd_data is zero, and every word of every block reads as zero.
- R2: A request is accepted on a rising edge where req_valid is high and busy is low. busy is high in the cycle that follows. Cycle n=0 is the first cycle after the accepting edge.
- R3: With INTERLEAVE=1, a read drives word k (k=0..3) with rd_valid high in cycle n=ACC_LAT+k. The whole transaction spans 1+ACC_LAT+4 cycles, which is 20 at ACC_LAT=15.
- R4: With INTERLEAVE=0, a read drives word k in cycle n=(k+1)*(ACC_LAT+1)-1. The whole transaction spans 1+4*ACC_LAT+4 cycles, which is 65 at ACC_LAT=15.
- R5: Words are returned in ascending order, 0 then 1, 2, 3. While rd_valid is high, rd_data equals word k of the addressed block. While rd_valid is low, rd_data is zero.
- R6: A read gives exactly four rd_valid cycles, and rd_valid is never high outside busy.
- R7: A write takes wr_data in cycles n=0..3 as words 0..3 of the addressed block. It never raises rd_valid. After the data cycles, busy is held for ACC_LAT cycles with INTERLEAVE=1, or for 4*ACC_LAT cycles with INTERLEAVE=0. A write therefore spans the same total as a read in the same mode.
- R8: busy is high for cycles n=0..TOTAL-2 and low from n=TOTAL-1, where TOTAL is the span given in R3, R4 or R7. A new request can be accepted at the end of cycle n=TOTAL-1.
- R9: A request presented while busy is high is ignored. It leaves the stored data and the timing of the current transaction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = block write, 0 = block read |
| req_addr | input | BLK_AW | Block address |
| wr_data | input | DATA_W | Write word, in cycles n=0..3 of a write |
| busy | output | 1 | Transaction in progress; requests ignored |
| rd_valid | output | 1 | Read word on rd_data this cycle |
| rd_data | output | DATA_W | Read word, zero when not valid |

## Verification
The bench builds two copies from the same stimulus. One uses INTERLEAVE=1 and the other INTERLEAVE=0, both with ACC_LAT=15, four words and eight blocks. Every operation is timed against both the 20-cycle and the 65-cycle schedules at once. The small block count makes random addresses reuse blocks often. This brings overwrite, read-back and the highest block address within reach of a short run. A request injected in the middle of a read checks that requests arriving while busy have no effect in either mode.

// File: rtl/iv_pkg.sv
// Shared definitions for the interleaved memory responder.
package iv_pkg;
    // Transaction sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WFILL = 2'd2,
        ST_WHOLD = 2'd3
    } iv_state_e;
endpackage

// File: rtl/iv_bank.sv
// One memory bank: holds one word position for every block.
// Assumes a single shared address for read and write, and that only
// one transaction at a time uses it. The read is combinational.
module iv_bank #(
    parameter int DATA_W = 32,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] cells [DEPTH];

    // Clear on reset, otherwise store the word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    // Present the addressed word.
    assign rdata = cells[addr];
endmodule

// File: rtl/iv_seq.sv
// Transaction sequencer. It accepts one request when idle and times
// the read transfers and the write capture and hold with one countdown.
// INTERLEAVE selects the overlapped access schedule (1) or the serial
// schedule (0). Assumes WORDS is a power of two.
module iv_seq
    import iv_pkg::*;
#(
    parameter int WORDS      = 4,
    parameter int ACC_LAT    = 15,
    parameter int INTERLEAVE = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    output logic                     accept,
    output logic                     busy,
    output logic [$clog2(WORDS)-1:0] word_idx,
    output logic                     rd_strobe,
    output logic                     wr_strobe
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int GAP_W = $clog2(WORDS * ACC_LAT + 1);
    localparam int GAP_AFTER = (INTERLEAVE != 0) ? 0 : ACC_LAT;
    localparam int HOLD      = (INTERLEAVE != 0) ? ACC_LAT : WORDS * ACC_LAT;
    localparam logic [GAP_W-1:0] FIRST_G = GAP_W'(ACC_LAT);
    localparam logic [GAP_W-1:0] AFTER_G = GAP_W'(GAP_AFTER);
    localparam logic [GAP_W-1:0] HOLD_G  = GAP_W'(HOLD - 1);
    localparam logic [IDX_W-1:0] LAST_W  = IDX_W'(WORDS - 1);

    iv_state_e        state;
    logic [GAP_W-1:0] gap;
    logic [IDX_W-1:0] widx;

    // Advance state, word index and countdown once per bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            gap   <= '0;
            widx  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state <= req_write ? ST_WFILL : ST_READ;
                        widx  <= '0;
                        gap   <= req_write ? '0 : FIRST_G;
                    end
                end
                ST_READ: begin
                    if (gap == '0) begin
                        if (widx == LAST_W) begin
                            state <= ST_IDLE;
                            widx  <= '0;
                        end else begin
                            widx <= widx + 1'b1;
                            gap  <= AFTER_G;
                        end
                    end else begin
                        gap <= gap - 1'b1;
                    end
                end
                ST_WFILL: begin
                    if (widx == LAST_W) begin
                        state <= ST_WHOLD;
                        widx  <= '0;
                        gap   <= HOLD_G;
                    end else begin
                        widx <= widx + 1'b1;
                    end
                end
                default: begin
                    if (gap == '0) state <= ST_IDLE;
                    else           gap   <= gap - 1'b1;
                end
            endcase
        end
    end

    // Decode the control outputs from the registered state.
    always_comb begin
        busy      = (state != ST_IDLE);
        accept    = (state == ST_IDLE) && req_valid;
        rd_strobe = (state == ST_READ) && (gap == '0);
        wr_strobe = (state == ST_WFILL);
        word_idx  = widx;
    end
endmodule

// File: rtl/iv_mem_responder.sv
// Block memory responder with one bank per word position. It latches
// the block address on acceptance, routes write words to their banks
// and selects the current bank onto the one-word read bus.
// Assumes WORDS is a power of two and the requester watches busy.
module iv_mem_responder #(
    parameter int DATA_W     = 32,
    parameter int BLK_AW     = 4,
    parameter int WORDS      = 4,
    parameter int ACC_LAT    = 15,
    parameter int INTERLEAVE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BLK_AW-1:0] req_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = $clog2(WORDS);

    logic              accept;
    logic              rd_strobe;
    logic              wr_strobe;
    logic [IDX_W-1:0]  widx;
    logic [BLK_AW-1:0] addr_q;
    logic [DATA_W-1:0] bank_q [WORDS];

    iv_seq #(
        .WORDS      (WORDS),
        .ACC_LAT    (ACC_LAT),
        .INTERLEAVE (INTERLEAVE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .accept    (accept),
        .busy      (busy),
        .word_idx  (widx),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe)
    );

    // Hold the block address for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= req_addr;
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_bank
        iv_bank #(
            .DATA_W (DATA_W),
            .AW     (BLK_AW)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_strobe && (widx == IDX_W'(g))),
            .addr  (addr_q),
            .wdata (wr_data),
            .rdata (bank_q[g])
        );
    end

    // Put the selected bank word on the bus during a transfer cycle.
    always_comb begin
        rd_valid = rd_strobe;
        rd_data  = rd_strobe ? bank_q[widx] : '0;
    end
endmodule

// File: rtl/iv_mem_checker.sv
// Port-level protocol checker for iv_mem_responder, attached by bind.
// Counts cycles and read strobes from each accepted request.
module iv_mem_checker #(
    parameter int DATA_W     = 32,
    parameter int WORDS      = 4,
    parameter int ACC_LAT    = 15,
    parameter int INTERLEAVE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              busy,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);
    localparam int TOTAL = (INTERLEAVE != 0) ? (1 + ACC_LAT + WORDS)
                                             : (1 + WORDS * ACC_LAT + WORDS);

    logic        acc_c;
    logic [15:0] cyc;
    logic [7:0]  nstb;
    logic        op_wr;

    assign acc_c = req_valid && !busy;

    // Track cycles, strobes and operation type since the last acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc   <= 16'hFFFF;
            nstb  <= '0;
            op_wr <= 1'b0;
        end else if (acc_c) begin
            cyc   <= 16'd1;
            nstb  <= '0;
            op_wr <= req_write;
        end else begin
            if (cyc != 16'hFFFF) cyc <= cyc + 16'd1;
            if (rd_valid)        nstb <= nstb + 8'd1;
        end
    end

    // R2: acceptance raises busy next cycle
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        acc_c |=> busy);
    // R8: busy ends exactly at the span of the transaction
    a_r8_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cyc == 16'(TOTAL)));
    // R9: requests during busy cannot cut the transaction short
    a_r9_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && (cyc < 16'(TOTAL - 1))) |=> busy);
    // R6: strobes only inside busy
    a_r6_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);
    // R6: never more than four strobes
    a_r6_strobe_limit: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (nstb < 8'(WORDS)));
    // R3: a finished read delivered all words
    a_r3_all_words: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !op_wr) |-> (nstb == 8'(WORDS)));
    // R7: writes raise no strobe
    a_r7_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_wr) |-> !rd_valid);
    // R5: bus is zero outside transfer cycles
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));
endmodule

bind iv_mem_responder iv_mem_checker #(
    .DATA_W     (DATA_W),
    .WORDS      (WORDS),
    .ACC_LAT    (ACC_LAT),
    .INTERLEAVE (INTERLEAVE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
);

// File: tb/iv_mem_responder_bench.sv
`timescale 1ns/1ps
// Drives an interleaved copy (index 0) and a serial copy (index 1)
// with the same stimulus and checks each against its own schedule.
module iv_mem_responder_bench;
    localparam int LAT = 15;
    localparam int BAW = 3;
    localparam int NBLK = 1 << BAW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [BAW-1:0] req_addr = '0;
    logic [31:0] wr_data = '0;
    logic        busy_w [2];
    logic        rdv_w  [2];
    logic [31:0] rdd_w  [2];

    logic [31:0] mem [NBLK][4];
    logic [31:0] wd [4];
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    iv_mem_responder #(.DATA_W(32), .BLK_AW(BAW), .WORDS(4), .ACC_LAT(LAT), .INTERLEAVE(1))
    u_iv_mem_responder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .wr_data(wr_data),
        .busy(busy_w[0]), .rd_valid(rdv_w[0]), .rd_data(rdd_w[0]));

    iv_mem_responder #(.DATA_W(32), .BLK_AW(BAW), .WORDS(4), .ACC_LAT(LAT), .INTERLEAVE(0))
    u_iv_mem_responder_ser (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .wr_data(wr_data),
        .busy(busy_w[1]), .rd_valid(rdv_w[1]), .rd_data(rdd_w[1]));

    function automatic int span(int m);
        return (m == 0) ? (1 + LAT + 4) : (1 + 4 * LAT + 4);
    endfunction

    // Word expected in cycle n of a read, or -1.
    function automatic int slot_word(int m, int n);
        if (m == 0) begin
            if (n >= LAT && n < LAT + 4) return n - LAT;
        end else if (((n + 1) % (LAT + 1)) == 0) begin
            if ((n + 1) / (LAT + 1) >= 1 && (n + 1) / (LAT + 1) <= 4)
                return (n + 1) / (LAT + 1) - 1;
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One transaction; poke injects a write request at n=5 while busy.
    task automatic run_op(input bit wr, input int addr, input bit poke, input string dtag);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = BAW'(addr);
        for (int n = 0; n < 68; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n == 0) req_valid = 1'b0;
            if (wr && n < 4) wr_data = wd[n];
            if (poke && n == 5) begin
                req_valid = 1'b1; req_write = 1'b1;
                req_addr = BAW'(addr + 1); wr_data = 32'hDEAD_0000 + 32'(n);
            end
            if (poke && n == 6) req_valid = 1'b0;
            for (int m = 0; m < 2; m++) begin
                int k;
                bit ebusy;
                k = wr ? -1 : slot_word(m, n);
                ebusy = (n < span(m) - 1);
                if (busy_w[m] !== ebusy)
                    chk(0, wr ? "R7" : (poke ? "R9" : "R8"), $sformatf("busy m%0d n%0d", m, n),
                        32'(busy_w[m]), 32'(ebusy));
                else checks++;
                if (rdv_w[m] !== (k >= 0))
                    chk(0, wr ? "R7" : (m == 0 ? "R3" : "R4"), $sformatf("rd_valid m%0d n%0d", m, n),
                        32'(rdv_w[m]), 32'(k >= 0));
                else checks++;
                if (k >= 0)
                    chk(rdd_w[m] === mem[addr][k], dtag, $sformatf("word%0d m%0d blk%0d", k, m, addr),
                        rdd_w[m], mem[addr][k]);
                else if (rdd_w[m] !== 32'h0)
                    chk(0, "R5", $sformatf("idle data m%0d n%0d", m, n), rdd_w[m], 32'h0);
                else checks++;
            end
        end
        if (wr) for (int k = 0; k < 4; k++) mem[addr][k] = wd[k];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1B5E_0042));
        for (int b = 0; b < NBLK; b++)
            for (int k = 0; k < 4; k++) mem[b][k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        for (int m = 0; m < 2; m++) begin
            chk(busy_w[m] === 1'b0, "R1", "busy after reset", 32'(busy_w[m]), 0);
            chk(rdv_w[m] === 1'b0, "R1", "rd_valid after reset", 32'(rdv_w[m]), 0);
            chk(rdd_w[m] === 32'h0, "R1", "rd_data after reset", rdd_w[m], 0);
        end
        // R1: never-written block reads zero
        run_op(0, 5, 0, "R1");
        // R7 then R5: write distinct words and read back in order
        for (int k = 0; k < 4; k++) wd[k] = 32'hA000_0000 + 32'(k * 17 + 1);
        run_op(1, 2, 0, "R7");
        run_op(0, 2, 0, "R5");
        // R7: edge blocks 0 and top
        for (int k = 0; k < 4; k++) wd[k] = 32'hFFFF_FFF0 | 32'(k);
        run_op(1, NBLK - 1, 0, "R7");
        for (int k = 0; k < 4; k++) wd[k] = 32'h0000_0001 << k;
        run_op(1, 0, 0, "R7");
        run_op(0, NBLK - 1, 0, "R5");
        run_op(0, 0, 0, "R5");
        // R9: write request during busy is dropped; block 3 stays zero
        run_op(0, 2, 1, "R9");
        run_op(0, 3, 0, "R9");
        // R2 and R6: random mix
        for (int i = 0; i < 24; i++) begin
            bit w;
            int a;
            w = ($urandom % 2) == 1;
            a = int'($urandom % NBLK);
            for (int k = 0; k < 4; k++) wd[k] = $urandom;
            run_op(w, a, 0, w ? "R7" : "R6");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule